// File: doc/BRIEF.md
# Single-Bit-Line Memory Access Sequencer

This block turns single-bit memory requests into the timed row and column controls of an array whose cells have one bit-line, one word-line, and a read-line that opens the cell's internal feedback loop while a read is in progress. A requester presents a valid, a write enable, a row address and a data bit. When the sequencer is ready, it accepts the request and steps through a fixed series of phases. Each phase lasts a parameterised number of cycles. The sequencer then pulses done, and for a read it also presents the sensed bit.

At rest the bit-line is driven low, not precharged high. A write places its data on the bit-line before the chosen word-line rises, so a zero write never moves the bit-line. A read first pulls the bit-line low and then releases it. Next it raises the read-line, and only then opens the word-line. Sensing waits until the word-line and the read-line are both back at rest.

Top module: `sb_sram_seq`

## Requirements
- R1: While in reset, and whenever the sequencer is ready, the outputs are at their rest levels. The word-line bus is all zero, which means idle bias. The bit-line drive enable is 1 with drive value 0. The read-line, the sense enable and done are all 0. Reset puts these levels on the outputs at once, without waiting for a clock edge.
- R2: A request is taken only on a clock edge where valid and ready are both 1. From that edge until the cycle in which done is 1, ready is 0. Changes to valid, address, write enable or data during that time have no effect.
- R3: A write drives its data bit with the drive enable at 1 for T_WDRV cycles while every word-line is idle. It then keeps the same drive and raises the selected word-line for T_WLA cycles. The read-line stays 0 for the whole write.
- R4: A write of 0 keeps the bit-line drive value at 0 in every cycle of the access.
- R5: A read holds the drive enable at 1 with value 0 for T_PRE cycles. It then sets the drive enable to 0, leaving the bit-line floating, for T_FLT cycles. Next the read-line is 1 for T_RLS cycles with every word-line idle. Then the selected word-line and the read-line are both 1 for T_WLA cycles. The bit-line stays floating from the float phase until the read ends.
- R6: After the word-line phase, a read spends T_REC cycles with the word-line and the read-line both at rest. It then asserts the sense enable for T_SNS cycles. The sense enable is never 1 while a word-line or the read-line is 1.
- R7: The value of the sense input in the last sense cycle becomes the read data output. The read data output holds that value until the next read completes.
- R8: done is 1 for exactly one cycle. For a request taken at edge k, done is 1 in the cycle after edge k+T_WDRV+T_WLA for a write. For a read, it is 1 in the cycle after edge k+T_PRE+T_FLT+T_RLS+T_WLA+T_REC+T_SNS. That same cycle is the first ready cycle.
- R9: The active word-line is bit number `addr` of the word-line bus, and at most one bit of the bus is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, able to take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Row address |
| req_wdata_i | input | 1 | Bit to write |
| wl_o | output | ROWS | One-hot word-line select, 0 = idle bias |
| bl_oe_o | output | 1 | Bit-line driver enable, 0 = floating |
| bl_do_o | output | 1 | Bit-line drive value |
| rl_o | output | 1 | Read-line, 1 = cell feedback cut |
| sae_o | output | 1 | Sense-amplifier enable |
| sense_i | input | 1 | Sense-amplifier output |
| rdata_o | output | 1 | Last sensed bit |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several orderings on every cycle:
- rest levels whenever the sequencer is ready;
- a floating bit-line whenever the read-line is up;
- a read-line that is up whenever a word-line opens on a floating bit-line;
- a quiet array while sensing;
- a one-hot word-line;
- written data already on the bit-line when the word-line rises;
- a single-cycle done pulse.

The bench's scenarios show the exact phase lengths and the row that is selected. They also show the latency to done, the value captured from the array, and that writes and reads of both values round-trip through a model of the array. Finally, they show that request changes during an access and a reset in mid-read both leave the stored data untouched.

// File: rtl/sb_seq_pkg.sv
package sb_seq_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_WDRV,   // write data on bit-line, word-line idle
    PH_WWL,    // write word-line high
    PH_PRE,    // read bit-line pulled low
    PH_FLT,    // read bit-line released
    PH_RLS,    // read-line up, feedback cut
    PH_RWL,    // read word-line high
    PH_REC,    // word-line and read-line back at rest
    PH_SNS     // sense amplifier on
  } phase_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sb_phase_timer.sv
module sb_phase_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [CW-1:0] len_m1_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == len_m1_i);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> cnt_q != '0); // R8
endmodule

// File: rtl/sb_phase_fsm.sv
module sb_phase_fsm
  import sb_seq_pkg::*;
#(
  parameter int unsigned T_WDRV = 2,
  parameter int unsigned T_PRE  = 2,
  parameter int unsigned T_FLT  = 1,
  parameter int unsigned T_RLS  = 1,
  parameter int unsigned T_WLA  = 3,
  parameter int unsigned T_REC  = 1,
  parameter int unsigned T_SNS  = 2,
  parameter int unsigned CW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic          last_i,
  output phase_e        phase_o,
  output logic          restart_o,
  output logic [CW-1:0] len_m1_o,
  output logic          fin_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (start_i) ph_d = we_i ? PH_WDRV : PH_PRE;
      PH_WDRV: if (last_i)  ph_d = PH_WWL;
      PH_WWL:  if (last_i)  ph_d = PH_IDLE;
      PH_PRE:  if (last_i)  ph_d = PH_FLT;
      PH_FLT:  if (last_i)  ph_d = PH_RLS;
      PH_RLS:  if (last_i)  ph_d = PH_RWL;
      PH_RWL:  if (last_i)  ph_d = PH_REC;
      PH_REC:  if (last_i)  ph_d = PH_SNS;
      PH_SNS:  if (last_i)  ph_d = PH_IDLE;
      default:              ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (ph_q)
      PH_WDRV: len_m1_o = CW'(T_WDRV - 1);
      PH_WWL:  len_m1_o = CW'(T_WLA - 1);
      PH_PRE:  len_m1_o = CW'(T_PRE - 1);
      PH_FLT:  len_m1_o = CW'(T_FLT - 1);
      PH_RLS:  len_m1_o = CW'(T_RLS - 1);
      PH_RWL:  len_m1_o = CW'(T_WLA - 1);
      PH_REC:  len_m1_o = CW'(T_REC - 1);
      PH_SNS:  len_m1_o = CW'(T_SNS - 1);
      default: len_m1_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  assign phase_o   = ph_q;
  assign restart_o = (ph_d != ph_q) || (ph_q == PH_IDLE);
  assign fin_o     = (ph_q != PH_IDLE) && (ph_d == PH_IDLE);
endmodule

// File: rtl/sb_wl_decode.sv
module sb_wl_decode #(
  parameter int unsigned ROWS = 16,
  localparam int unsigned AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            en_i,
  input  logic [AW-1:0]   addr_i,
  output logic [ROWS-1:0] wl_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign wl_o[r] = en_i && (addr_i == AW'(r));
  end
endmodule

// File: rtl/sb_sram_seq.sv
module sb_sram_seq
  import sb_seq_pkg::*;
#(
  parameter int unsigned ROWS   = 16,
  parameter int unsigned T_WDRV = 2,
  parameter int unsigned T_PRE  = 2,
  parameter int unsigned T_FLT  = 1,
  parameter int unsigned T_RLS  = 1,
  parameter int unsigned T_WLA  = 3,
  parameter int unsigned T_REC  = 1,
  parameter int unsigned T_SNS  = 2,
  localparam int unsigned AW    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic            req_wdata_i,
  output logic [ROWS-1:0] wl_o,
  output logic            bl_oe_o,
  output logic            bl_do_o,
  output logic            rl_o,
  output logic            sae_o,
  input  logic            sense_i,
  output logic            rdata_o,
  output logic            done_o
);
  localparam int unsigned TMAX = max2(max2(max2(T_WDRV, T_PRE), max2(T_FLT, T_RLS)),
                                      max2(max2(T_WLA, T_REC), T_SNS));
  localparam int unsigned CW   = $clog2(TMAX + 1) + 1;

  phase_e        phase;
  logic          restart, last, fin, accept;
  logic [CW-1:0] len_m1;
  logic          we_q, wd_q, rdata_q, done_q, wl_en;
  logic [AW-1:0] addr_q;

  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      wd_q   <= 1'b0;
      addr_q <= '0;
    end else if (accept) begin
      we_q   <= req_we_i;
      wd_q   <= req_wdata_i;
      addr_q <= req_addr_i;
    end
  end

  sb_phase_fsm #(
    .T_WDRV(T_WDRV), .T_PRE(T_PRE), .T_FLT(T_FLT), .T_RLS(T_RLS),
    .T_WLA(T_WLA), .T_REC(T_REC), .T_SNS(T_SNS), .CW(CW)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .we_i      (req_we_i),
    .last_i    (last),
    .phase_o   (phase),
    .restart_o (restart),
    .len_m1_o  (len_m1),
    .fin_o     (fin)
  );

  sb_phase_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .len_m1_i  (len_m1),
    .last_o    (last)
  );

  assign wl_en = (phase == PH_WWL) || (phase == PH_RWL);

  sb_wl_decode #(.ROWS(ROWS)) u_dec (
    .en_i   (wl_en),
    .addr_i (addr_q),
    .wl_o   (wl_o)
  );

  always_comb begin
    bl_oe_o = 1'b1;
    bl_do_o = 1'b0;
    rl_o    = 1'b0;
    sae_o   = 1'b0;
    unique case (phase)
      PH_WDRV, PH_WWL: bl_do_o = wd_q;
      PH_FLT, PH_REC:  bl_oe_o = 1'b0;
      PH_RLS, PH_RWL: begin
        bl_oe_o = 1'b0;
        rl_o    = 1'b1;
      end
      PH_SNS: begin
        bl_oe_o = 1'b0;
        sae_o   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin;
      if ((phase == PH_SNS) && last) rdata_q <= sense_i;
    end
  end

  assign req_ready_o = (phase == PH_IDLE);
  assign rdata_o     = rdata_q;
  assign done_o      = done_q;

  AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (wl_o == '0) && bl_oe_o && !bl_do_o && !rl_o && !sae_o); // R1
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(addr_q) && $stable(we_q) && $stable(wd_q)); // R2
  AST_WR_RL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wl_o != '0) && bl_oe_o) |-> !rl_o); // R3
  AST_WR_DATA_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(|wl_o) && bl_oe_o) |-> $past(bl_oe_o) && $stable(bl_do_o)); // R3
  AST_RL_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rl_o |-> !bl_oe_o); // R5
  AST_FLOAT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rl_o) |-> !$past(bl_oe_o)); // R5
  AST_RD_WL_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wl_o != '0) && !bl_oe_o) |-> rl_o); // R5
  AST_SENSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sae_o |-> (wl_o == '0) && !rl_o && !bl_oe_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_WL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wl_o)); // R9
endmodule

// File: tb/tb_sb_sram_seq.sv
module tb_sb_sram_seq;
  localparam int ROWS = 16;
  localparam int AW = $clog2(ROWS);
  localparam int T_WDRV = 2, T_PRE = 2, T_FLT = 1, T_RLS = 1, T_WLA = 3, T_REC = 1, T_SNS = 2;

  typedef struct packed {
    logic [ROWS-1:0] wl;
    logic oe;
    logic dout;
    logic rl;
    logic sae;
  } sig_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, bl_oe, bl_do, rl, sae, sense, rdata, done;
  logic [ROWS-1:0] wl;

  int checks = 0, errors = 0;
  logic arr [ROWS] = '{default: 1'b0};
  logic ref_mem [ROWS] = '{default: 1'b0};
  logic bl_node = 1'b0;

  always #4 clk = ~clk;

  sb_sram_seq #(
    .ROWS(ROWS), .T_WDRV(T_WDRV), .T_PRE(T_PRE), .T_FLT(T_FLT), .T_RLS(T_RLS),
    .T_WLA(T_WLA), .T_REC(T_REC), .T_SNS(T_SNS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .wl_o(wl), .bl_oe_o(bl_oe), .bl_do_o(bl_do), .rl_o(rl), .sae_o(sae),
    .sense_i(sense), .rdata_o(rdata), .done_o(done)
  );

  function automatic int wl_index(logic [ROWS-1:0] v);
    int idx = 0;
    for (int r = 0; r < ROWS; r++) if (v[r]) idx = r;
    return idx;
  endfunction

  // behavioural array with a single bit-line node
  always @(posedge clk) begin
    if (|wl && bl_oe) arr[wl_index(wl)] <= bl_do;
    if (bl_oe) bl_node <= bl_do;
    else if (|wl && rl) bl_node <= arr[wl_index(wl)];
  end
  assign sense = sae ? bl_node : 1'b0;

  function automatic int lat(bit we);
    return we ? (T_WDRV + T_WLA) : (T_PRE + T_FLT + T_RLS + T_WLA + T_REC + T_SNS);
  endfunction

  function automatic sig_t exp_sig(bit we, int addr, bit wd, int j);
    sig_t s;
    int b0, b1, b2, b3, b4;
    s = '{wl: '0, oe: 1'b1, dout: 1'b0, rl: 1'b0, sae: 1'b0};
    if (we) begin
      s.dout = wd;
      if (j >= T_WDRV) s.wl[addr] = 1'b1;
    end else begin
      b0 = T_PRE; b1 = b0 + T_FLT; b2 = b1 + T_RLS; b3 = b2 + T_WLA; b4 = b3 + T_REC;
      if (j >= b0) begin
        s.oe = 1'b0;
        if (j >= b1 && j < b3) s.rl = 1'b1;
        if (j >= b2 && j < b3) s.wl[addr] = 1'b1;
        if (j >= b4) s.sae = 1'b1;
      end
    end
    return s;
  endfunction

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_idle(string req);
    cmp(req, "wl", 32'(wl), 0);
    cmp(req, "oe/do/rl/sae", {28'd0, bl_oe, bl_do, rl, sae}, 32'h8);
  endtask

  task automatic access(bit we, int addr, bit wd);
    sig_t e;
    string rq;
    int n = lat(we);
    req_valid = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = wd;
    cmp("R2", "ready before accept", 32'(req_ready), 1);
    @(posedge clk); @(negedge clk);
    for (int j = 0; j < n; j++) begin
      e = exp_sig(we, addr, wd, j);
      rq = we ? "R3" : ((j >= T_PRE + T_FLT + T_RLS + T_WLA) ? "R6" : "R5");
      cmp("R9", "wl select", 32'(wl), 32'(e.wl));
      cmp(rq, "bl_oe", 32'(bl_oe), 32'(e.oe));
      cmp((we && !wd) ? "R4" : rq, "bl_do", 32'(bl_do), 32'(e.dout));
      cmp(rq, "rl", 32'(rl), 32'(e.rl));
      cmp("R6", "sae", 32'(sae), 32'(e.sae));
      cmp("R2", "ready busy", 32'(req_ready), 0);
      cmp("R8", "done early", 32'(done), 0);
      // junk request while busy, withdrawn before the idle edge
      req_valid = (j < n - 1);
      req_we = 1'b1; req_addr = AW'($urandom_range(ROWS - 1)); req_wdata = 1'($urandom);
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (we) ref_mem[addr] = wd;
    cmp("R8", "done pulse", 32'(done), 1);
    cmp("R8", "ready at done", 32'(req_ready), 1);
    check_idle("R1");
    if (!we) cmp("R7", "rdata", 32'(rdata), 32'(ref_mem[addr]));
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed1234));
    #3;
    check_idle("R1");
    cmp("R1", "done in reset", 32'(done), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    // directed corners
    access(1'b1, 0, 1'b0);
    access(1'b1, ROWS - 1, 1'b1);
    access(1'b0, ROWS - 1, 1'b0);
    access(1'b0, 0, 1'b0);
    access(1'b1, ROWS - 1, 1'b0);
    access(1'b0, ROWS - 1, 1'b0);
    access(1'b1, 5, 1'b1);
    @(negedge clk);
    cmp("R8", "done single cycle", 32'(done), 0);
    cmp("R7", "rdata held after write", 32'(rdata), 0);
    // reset mid-read
    req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(5);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    repeat (T_PRE + T_FLT + T_RLS) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R1");
    cmp("R1", "ready in reset", 32'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 5, 1'b0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      bit we = 1'($urandom);
      int a = $urandom_range(ROWS - 1);
      bit d = ($urandom_range(3) == 0);
      access(we, a, d);
      if ($urandom_range(3) == 0) begin
        @(negedge clk);
        cmp("R8", "done gap", 32'(done), 0);
        check_idle("R1");
      end
    end
    for (int r = 0; r < ROWS; r++) access(1'b0, r, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule